// File: doc/BRIEF.md
# SRAM Page Selection Unit

This block sits beside the core of an 8-bit microcontroller whose data SRAM is split into pages. It holds three page-pointer registers: one for the stack, one for indexed accesses and one for the data fetch of a move-indirect read. Software reads and writes these registers over a simple register bus. The bus carries a bank bit, an address, a write strobe and write data, and returns read data without delay.

For every data memory access, the core presents an access-type code, the 2-bit paging-mode flags and its current page number. The block answers in the same cycle with the effective SRAM page for that access. Stack traffic always follows the stack pointer register. Indexed traffic is steered by the paging mode to the stack page, the index page or page 0. A move-indirect read takes its pointer byte from the current page and its data byte from the move-indirect read page.

Top module: `sram_page_sel`

## Requirements
- R1: While reset is asserted and after it is released, all three page registers hold 0. Reading any of them returns 0x00, and a stack access (access code 3'd1) yields page 0.
- R2: When the bank bit is 0, a write lands at address 0xD1 (stack page), 0xD3 (index page) or 0xD4 (move-indirect read page). Only the low PAGE_W bits of the write data are kept (bit 0 with the default of two pages). A read of that address returns the stored page in the low bits with every upper bit 0.
- R3: A write with the bank bit at 1, or to any other address, leaves all three registers unchanged. A read of an unmapped address, or with the bank bit at 1, returns 0x00.
- R4: A stack access (code 3'd1) yields the stack page register, for every value of the paging mode.
- R5: A register write takes effect on the clock edge at which the strobe is sampled. The very next stack access after that edge already uses the new stack page.
- R6: An indexed access (code 3'd2) with paging mode 2'b11 yields the stack page register.
- R7: An indexed access with paging mode 2'b10 yields the index page register.
- R8: An indexed access with paging mode 2'b00 or 2'b01 yields page 0.
- R9: The pointer fetch of a move-indirect read (code 3'd3) yields the current-page input, whatever the paging mode.
- R10: The data fetch of a move-indirect read (code 3'd4) yields the move-indirect read page register, whatever the paging mode.
- R11: A direct access (code 3'd0) and the unused codes 3'd5 to 3'd7 yield the current-page input. The effective page follows its inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_bank | input | 1 | Register bank select; the page registers live in bank 0 |
| reg_addr | input | ADDR_W (8) | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data of the addressed register, combinational |
| acc_type | input | 3 | Access type: 0 direct, 1 stack, 2 indexed, 3 move-indirect pointer, 4 move-indirect data |
| pg_mode | input | 2 | Paging-mode flag bits of the core |
| cur_page | input | PAGE_W (1) | Current SRAM page of the core |
| eff_page | output | PAGE_W (1) | Effective SRAM page for the presented access |

## Verification
Each table vector loads the three registers and the current page with its own mix of values. The three candidate sources then hold differing pages, so a wrong source selection shows up as a wrong output. Indexed accesses are swept through all four paging modes; the cases with the stack and index registers set to opposite values separate mode 2'b11 from mode 2'b10. Both move-indirect phases and the stack access are driven under modes that would steer an indexed access elsewhere, which shows that the paging mode does not affect them. Directed tests cover readback with all write-data bits set, writes to the wrong bank and to an unmapped address, and the one-edge latency of a stack page change.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;

   typedef enum logic [2:0] {
      ACC_DIRECT   = 3'd0,
      ACC_STACK    = 3'd1,
      ACC_INDEX    = 3'd2,
      ACC_MVI_PTR  = 3'd3,
      ACC_MVI_DATA = 3'd4
   } acc_t;

   localparam int unsigned NUM_PTR = 3;
   localparam int unsigned PTR_STK = 0;
   localparam int unsigned PTR_IDX = 1;
   localparam int unsigned PTR_MRD = 2;

   localparam logic [1:0] MODE_TO_STACK = 2'b11;
   localparam logic [1:0] MODE_TO_INDEX = 2'b10;

endpackage

// File: rtl/pgsel_decode.sv
module pgsel_decode #(
   parameter int unsigned ADDR_W        = 8,
   parameter logic        BANK_SEL      = 1'b0,
   parameter int unsigned STACK_PG_ADDR = 'hD1,
   parameter int unsigned INDEX_PG_ADDR = 'hD3,
   parameter int unsigned MRD_PG_ADDR   = 'hD4
) (
   input  logic                            bank,
   input  logic [ADDR_W-1:0]               addr,
   input  logic                            we,
   output logic [pgsel_pkg::NUM_PTR-1:0]   hit,
   output logic [pgsel_pkg::NUM_PTR-1:0]   wr
);
   import pgsel_pkg::*;

   localparam int unsigned N = NUM_PTR;
   localparam logic [ADDR_W-1:0] ADDR_TAB [N] = '{
      ADDR_W'(STACK_PG_ADDR), ADDR_W'(INDEX_PG_ADDR), ADDR_W'(MRD_PG_ADDR)
   };

   logic bank_ok;
   assign bank_ok = (bank == BANK_SEL);

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = bank_ok && (addr == ADDR_TAB[i]);
      assign wr[i]  = hit[i] && we;
   end

endmodule

// File: rtl/pgsel_ptr_reg.sv
module pgsel_ptr_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [PAGE_W-1:0] page
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page <= '0;
      end else if (wr_en) begin
         page <= wdata[PAGE_W-1:0];
      end
   end

endmodule

// File: rtl/pgsel_route.sv
module pgsel_route #(
   parameter int unsigned PAGE_W = 1
) (
   input  logic [2:0]        acc,
   input  logic [1:0]        mode,
   input  logic [PAGE_W-1:0] cur_pg,
   input  logic [PAGE_W-1:0] stk_pg,
   input  logic [PAGE_W-1:0] idx_pg,
   input  logic [PAGE_W-1:0] mrd_pg,
   output logic [PAGE_W-1:0] page
);
   import pgsel_pkg::*;

   logic [PAGE_W-1:0] index_sel;

   always_comb begin
      unique case (mode)
         MODE_TO_STACK: index_sel = stk_pg;
         MODE_TO_INDEX: index_sel = idx_pg;
         default:       index_sel = '0;
      endcase
   end

   always_comb begin
      case (acc)
         ACC_STACK:    page = stk_pg;
         ACC_INDEX:    page = index_sel;
         ACC_MVI_PTR:  page = cur_pg;
         ACC_MVI_DATA: page = mrd_pg;
         default:      page = cur_pg;
      endcase
   end

endmodule

// File: rtl/sram_page_sel.sv
module sram_page_sel #(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned PAGE_W        = 1,
   parameter logic        BANK_SEL      = 1'b0,
   parameter int unsigned STACK_PG_ADDR = 'hD1,
   parameter int unsigned INDEX_PG_ADDR = 'hD3,
   parameter int unsigned MRD_PG_ADDR   = 'hD4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_bank,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [2:0]        acc_type,
   input  logic [1:0]        pg_mode,
   input  logic [PAGE_W-1:0] cur_page,
   output logic [PAGE_W-1:0] eff_page
);
   import pgsel_pkg::*;

   localparam int unsigned N      = NUM_PTR;
   localparam int unsigned FILL_W = DATA_W - PAGE_W;

   if (PAGE_W < 1 || PAGE_W >= DATA_W) begin : g_bad_page_w
      $error("sram_page_sel: PAGE_W must be in 1..DATA_W-1");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("sram_page_sel: ADDR_W must be in 1..32");
   end
   if (STACK_PG_ADDR == INDEX_PG_ADDR || STACK_PG_ADDR == MRD_PG_ADDR ||
       INDEX_PG_ADDR == MRD_PG_ADDR) begin : g_bad_map
      $error("sram_page_sel: register addresses must differ");
   end

   logic [N-1:0]      hit;
   logic [N-1:0]      wr;
   logic [PAGE_W-1:0] pg [N];
   logic [PAGE_W-1:0] stk_pg;
   logic [PAGE_W-1:0] idx_pg;
   logic [PAGE_W-1:0] mrd_pg;

   pgsel_decode #(
      .ADDR_W        (ADDR_W),
      .BANK_SEL      (BANK_SEL),
      .STACK_PG_ADDR (STACK_PG_ADDR),
      .INDEX_PG_ADDR (INDEX_PG_ADDR),
      .MRD_PG_ADDR   (MRD_PG_ADDR)
   ) u_decode (
      .bank (reg_bank),
      .addr (reg_addr),
      .we   (reg_we),
      .hit  (hit),
      .wr   (wr)
   );

   for (genvar i = 0; i < N; i++) begin : g_ptr
      pgsel_ptr_reg #(
         .DATA_W (DATA_W),
         .PAGE_W (PAGE_W)
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr[i]),
         .wdata (reg_wdata),
         .page  (pg[i])
      );
   end

   assign stk_pg = pg[PTR_STK];
   assign idx_pg = pg[PTR_IDX];
   assign mrd_pg = pg[PTR_MRD];

   always_comb begin
      logic [PAGE_W-1:0] acc_rd;
      acc_rd = '0;
      for (int i = 0; i < N; i++) begin
         if (hit[i]) acc_rd = acc_rd | pg[i];
      end
      reg_rdata = {{FILL_W{1'b0}}, acc_rd};
   end

   pgsel_route #(
      .PAGE_W (PAGE_W)
   ) u_route (
      .acc    (acc_type),
      .mode   (pg_mode),
      .cur_pg (cur_page),
      .stk_pg (stk_pg),
      .idx_pg (idx_pg),
      .mrd_pg (mrd_pg),
      .page   (eff_page)
   );

endmodule

// File: rtl/sram_page_sel_chk.sv
module sram_page_sel_chk #(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned PAGE_W        = 1,
   parameter logic        BANK_SEL      = 1'b0,
   parameter int unsigned STACK_PG_ADDR = 'hD1,
   parameter int unsigned INDEX_PG_ADDR = 'hD3,
   parameter int unsigned MRD_PG_ADDR   = 'hD4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_bank,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [2:0]        acc_type,
   input logic [1:0]        pg_mode,
   input logic [PAGE_W-1:0] cur_page,
   input logic [PAGE_W-1:0] eff_page,
   input logic [PAGE_W-1:0] stk_pg,
   input logic [PAGE_W-1:0] idx_pg,
   input logic [PAGE_W-1:0] mrd_pg
);

   logic mapped;
   assign mapped = (reg_bank == BANK_SEL) &&
                   (reg_addr == ADDR_W'(STACK_PG_ADDR) ||
                    reg_addr == ADDR_W'(INDEX_PG_ADDR) ||
                    reg_addr == ADDR_W'(MRD_PG_ADDR));

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (stk_pg == '0 && idx_pg == '0 && mrd_pg == '0));

   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata >> PAGE_W) == '0);

   a_r3_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !mapped) |=> ($stable(stk_pg) && $stable(idx_pg) && $stable(mrd_pg)));

   a_r3_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> reg_rdata == '0);

   a_r4_stack: assert property (@(posedge clk) disable iff (!rst_n)
      acc_type == 3'd1 |-> eff_page == stk_pg);

   a_r5_stack_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_bank == BANK_SEL && reg_addr == ADDR_W'(STACK_PG_ADDR))
      |=> stk_pg == $past(reg_wdata[PAGE_W-1:0]));

   a_r6_idx_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == 3'd2 && pg_mode == 2'b11) |-> eff_page == stk_pg);

   a_r7_idx_index: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == 3'd2 && pg_mode == 2'b10) |-> eff_page == idx_pg);

   a_r8_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == 3'd2 && !pg_mode[1]) |-> eff_page == '0);

   a_r9_mvi_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      acc_type == 3'd3 |-> eff_page == cur_page);

   a_r10_mvi_data: assert property (@(posedge clk) disable iff (!rst_n)
      acc_type == 3'd4 |-> eff_page == mrd_pg);

   a_r11_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == 3'd0 || acc_type > 3'd4) |-> eff_page == cur_page);

endmodule

bind sram_page_sel sram_page_sel_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .PAGE_W        (PAGE_W),
   .BANK_SEL      (BANK_SEL),
   .STACK_PG_ADDR (STACK_PG_ADDR),
   .INDEX_PG_ADDR (INDEX_PG_ADDR),
   .MRD_PG_ADDR   (MRD_PG_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_bank  (reg_bank),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .acc_type  (acc_type),
   .pg_mode   (pg_mode),
   .cur_page  (cur_page),
   .eff_page  (eff_page),
   .stk_pg    (stk_pg),
   .idx_pg    (idx_pg),
   .mrd_pg    (mrd_pg)
);

// File: tb/sram_page_sel_bench.sv
module sram_page_sel_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_bank = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [2:0] acc_type = 3'd0;
   logic [1:0] pg_mode = 2'b00;
   logic [0:0] cur_page = 1'b0;
   logic [0:0] eff_page;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   sram_page_sel u_sram_page_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_bank  (reg_bank),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .acc_type  (acc_type),
      .pg_mode   (pg_mode),
      .cur_page  (cur_page),
      .eff_page  (eff_page)
   );

   // {req, stk, idx, mrd, cur, mode, acc, expected}
   localparam int NV = 16;
   localparam logic [13:0] VEC [NV] = '{
      {4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'd1, 1'b1},  // R4
      {4'd4,  1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 3'd1, 1'b0},  // R4
      {4'd6,  1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 3'd2, 1'b1},  // R6
      {4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 3'd2, 1'b0},  // R6
      {4'd7,  1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 3'd2, 1'b1},  // R7
      {4'd7,  1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 3'd2, 1'b0},  // R7
      {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 3'd2, 1'b0},  // R8
      {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 3'd2, 1'b0},  // R8
      {4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 3'd3, 1'b1},  // R9
      {4'd9,  1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 3'd3, 1'b0},  // R9
      {4'd10, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 3'd4, 1'b1},  // R10
      {4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 3'd4, 1'b0},  // R10
      {4'd11, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 3'd0, 1'b1},  // R11
      {4'd11, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 3'd0, 1'b0},  // R11
      {4'd11, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 3'd5, 1'b1},  // R11
      {4'd11, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 3'd7, 1'b0}   // R11
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive a bus write; the register updates at the next rising edge
   task automatic bus_wr(input logic bank, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_bank = bank; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_bank = 1'b0;
   endtask

   task automatic bus_rd(input logic bank, input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_bank = bank; reg_addr = a;
      #1 d = reg_rdata;
      reg_bank = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      // R1: reset state, checked while reset is held
      acc_type = 3'd1;
      #1 check("R1", {7'd0, eff_page}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      bus_rd(1'b0, 8'hD1, rd); check("R1", rd, 8'h00);
      bus_rd(1'b0, 8'hD3, rd); check("R1", rd, 8'h00);
      bus_rd(1'b0, 8'hD4, rd); check("R1", rd, 8'h00);

      // table walk for the page selection rules
      for (int v = 0; v < NV; v++) begin
         bus_wr(1'b0, 8'hD1, {7'd0, VEC[v][9]});
         bus_wr(1'b0, 8'hD3, {7'd0, VEC[v][8]});
         bus_wr(1'b0, 8'hD4, {7'd0, VEC[v][7]});
         @(negedge clk);
         cur_page = VEC[v][6];
         pg_mode  = VEC[v][5:4];
         acc_type = VEC[v][3:1];
         #1 check($sformatf("R%0d vec %0d", VEC[v][13:10], v), {7'd0, eff_page}, {7'd0, VEC[v][0]});
      end

      // R2: only the page bit is kept, upper bits read 0
      bus_wr(1'b0, 8'hD1, 8'hFF);
      bus_rd(1'b0, 8'hD1, rd); check("R2", rd, 8'h01);
      bus_wr(1'b0, 8'hD3, 8'hFE);
      bus_rd(1'b0, 8'hD3, rd); check("R2", rd, 8'h00);
      bus_wr(1'b0, 8'hD4, 8'h81);
      bus_rd(1'b0, 8'hD4, rd); check("R2", rd, 8'h01);

      // R3: wrong bank and unmapped address leave registers alone
      bus_wr(1'b1, 8'hD1, 8'h00);
      bus_wr(1'b1, 8'hD4, 8'h00);
      bus_wr(1'b0, 8'hD2, 8'h00);
      bus_rd(1'b0, 8'hD1, rd); check("R3", rd, 8'h01);
      bus_rd(1'b0, 8'hD4, rd); check("R3", rd, 8'h01);
      bus_rd(1'b1, 8'hD1, rd); check("R3", rd, 8'h00);
      bus_rd(1'b0, 8'hD2, rd); check("R3", rd, 8'h00);

      // R5: stack page change seen by the first stack access after the edge
      @(negedge clk);
      acc_type = 3'd1; pg_mode = 2'b00;
      reg_bank = 1'b0; reg_addr = 8'hD1; reg_wdata = 8'h00; reg_we = 1'b1;
      #1 check("R5 before edge", {7'd0, eff_page}, 8'h01);
      @(posedge clk);
      #1 reg_we = 1'b0;
      check("R5 after edge", {7'd0, eff_page}, 8'h00);

      // R1: reset clears a written register
      bus_wr(1'b0, 8'hD3, 8'h01);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_rd(1'b0, 8'hD3, rd); check("R1 re-reset", rd, 8'h00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule